// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block runs single transfers on an external memory bus whose low address bits and data share one set of pins. An internal requester presents an address, write data, direction, a bus width of 8 or 16 bits, a flag marking the target as internal space, and a one-hot chip-select choice. The block then sequences the pins through four stages: address with a latch strobe, read or write strobe, optional wait, and finish. It returns read data with a one-cycle done pulse.

The shared pins are given as separate drive, enable and input vectors, so the tri-state buffer sits outside the block. The external latch captures the address on the falling edge of the address-latch strobe, so that strobe drops one cycle before the address leaves the pins. The slave's ready line is sampled on the falling clock edge. While the slave holds it low, every pin output stays frozen. Each of the four topmost lines is configured on its own to carry either an address bit or an active-low chip select. The pairing runs in reverse: the highest address line carries chip select 0.

Top module: `mxbus_ctrl`

## Requirements
- R1: `req_ready` is high only when idle. A request is taken when `req_valid` is high at a clock edge while idle. Request inputs that change while a transfer is running have no effect on it.
- R2: The address stage lasts ADDR_CYC cycles and drives `req_addr[15:0]` on all 16 shared pins (`ad_oe` all ones). `ale` is high in every cycle of this stage except its last, so the address is still valid when `ale` falls.
- R3: In 8-bit mode, pins 15..8 carry address bits 15..8 with enable high for the whole transfer. Only pins 7..0 switch to data after the address stage.
- R4: In 16-bit mode, after the address stage a read releases all 16 pins (`ad_oe` = 0) and a write drives `req_wdata` on them. In 8-bit mode a write drives `req_wdata[7:0]` on pins 7..0 and a read releases those pins.
- R5: `a_mid` carries address bits 19..16 for the whole transfer.
- R6: Line `a_top[i]` carries address bit 20+i when `cs_mode[i]` is 0. When `cs_mode[i]` is 1 it carries active-low chip select 3-i, which is low only while an external transfer with `req_csel[3-i]` set is in progress.
- R7: For an external transfer, `rd_n` (read) or `wr_n` (write) is low for the STB_CYC cycles that follow the address stage and in any wait cycles. The other strobe stays high, and both are high in the finish cycle.
- R8: `ext_rdy` is sampled on the falling clock edge of the last strobe cycle. Each low sample, there or in a wait cycle, adds one more wait cycle. A high sample ends the strobe at the next rising edge.
- R9: During wait cycles, `ale`, both strobes, the shared-pin drive and enable, `a_mid` and `a_top` hold their values.
- R10: A finish cycle with `done` high for exactly one cycle follows the strobe. On a read, `rdata` then holds `ad_in` as captured at the edge that ended the strobe. In 8-bit mode the upper byte is zero. The next cycle is idle.
- R11: An internal-space transfer still runs the address stage with `ale`. Its strobes and chip selects stay inactive, it ignores `ext_rdy` (no waits), and it returns `rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Idle, request can be taken |
| req_addr | input | 24 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| req_internal | input | 1 | Target is internal space |
| req_csel | input | 4 | One-hot chip select for the transfer |
| cs_mode | input | 4 | Per top line: 1 = chip select, 0 = address bit |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with done |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ad_out | output | 16 | Shared address/data pin drive |
| ad_oe | output | 16 | Per-pin output enable for shared pins |
| ad_in | input | 16 | Shared pin input value |
| a_mid | output | 4 | Address bits 19..16 |
| a_top | output | 4 | Address bits 23..20 or chip selects |
| ext_rdy | input | 1 | Slave ready, low inserts wait states |

## Verification
The bench builds the block with ADDR_CYC = 3 and STB_CYC = 2. A three-cycle address stage exercises the counter past its first value and shows `ale` high for two cycles and low for one. A two-cycle strobe places the ready sample in a cycle other than the first. At this size every combination of width, direction, internal flag and zero to three wait cycles can be swept, with all 16 `cs_mode` patterns and all four chip selects. The expected value of every pin is checked in every cycle of every transfer.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ADDR = 3'd1,
      PH_STB  = 3'd2,
      PH_WAIT = 3'd3,
      PH_FIN  = 3'd4
   } mxb_phase_e;

   function automatic logic phase_is_data(mxb_phase_e ph);
      return (ph == PH_STB) || (ph == PH_WAIT) || (ph == PH_FIN);
   endfunction

   function automatic logic phase_is_strobe(mxb_phase_e ph);
      return (ph == PH_STB) || (ph == PH_WAIT);
   endfunction

endpackage

// File: rtl/mxb_rdy_sample.sv
module mxb_rdy_sample (
   input  logic clk,
   input  logic rst_n,
   input  logic rdy_pin,
   output logic rdy_fall
);
   // ready is taken on the falling edge, mid-cycle
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) rdy_fall <= 1'b1;
      else        rdy_fall <= rdy_pin;
   end
endmodule

// File: rtl/mxb_seq.sv
module mxb_seq
   import mxb_pkg::*;
#(
   parameter int LO_W     = 16,
   parameter int ADDR_W   = 24,
   parameter int CSN      = 4,
   parameter int ADDR_CYC = 2,
   parameter int STB_CYC  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [LO_W-1:0]    req_wdata,
   input  logic               req_write,
   input  logic               req_wide,
   input  logic               req_internal,
   input  logic [CSN-1:0]     req_csel,
   input  logic               rdy_fall,
   input  logic [LO_W-1:0]    ad_in,
   output logic               req_ready,
   output mxb_phase_e         phase,
   output logic               ale,
   output logic [ADDR_W-1:0]  r_addr,
   output logic [LO_W-1:0]    r_wdata,
   output logic               r_write,
   output logic               r_wide,
   output logic               r_int,
   output logic [CSN-1:0]     r_csel,
   output logic               done,
   output logic [LO_W-1:0]    rdata
);
   localparam int BYTE_W  = LO_W / 2;
   localparam int CNT_MAX = (ADDR_CYC > STB_CYC) ? ADDR_CYC : STB_CYC;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_CYC - 1);
   localparam logic [CNT_W-1:0] STB_LAST  = CNT_W'(STB_CYC - 1);

   logic [CNT_W-1:0] cnt;
   logic [LO_W-1:0]  cap_data;

   assign cap_data = r_int  ? '0 :
                     r_wide ? ad_in : {{BYTE_W{1'b0}}, ad_in[BYTE_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         r_addr  <= '0;
         r_wdata <= '0;
         r_write <= 1'b0;
         r_wide  <= 1'b0;
         r_int   <= 1'b0;
         r_csel  <= '0;
         rdata   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (req_valid) begin
               phase   <= PH_ADDR;
               cnt     <= '0;
               r_addr  <= req_addr;
               r_wdata <= req_wdata;
               r_write <= req_write;
               r_wide  <= req_wide;
               r_int   <= req_internal;
               r_csel  <= req_csel;
            end
            PH_ADDR: if (cnt == ADDR_LAST) begin
               phase <= PH_STB;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
            PH_STB: if (cnt == STB_LAST) begin
               if (r_int || rdy_fall) begin
                  phase <= PH_FIN;
                  rdata <= cap_data;
               end else begin
                  phase <= PH_WAIT;
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
            PH_WAIT: if (rdy_fall) begin
               phase <= PH_FIN;
               rdata <= cap_data;
            end
            PH_FIN:  phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign req_ready = (phase == PH_IDLE);
   assign done      = (phase == PH_FIN);
   assign ale       = (phase == PH_ADDR) && (cnt != ADDR_LAST);

   AST_INT_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (r_int && phase != PH_IDLE) |-> (phase != PH_WAIT))
      else $error("internal transfer entered wait"); // R11

   AST_FIN_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> req_ready)
      else $error("finish not followed by idle"); // R10
endmodule

// File: rtl/mxb_pinmux.sv
module mxb_pinmux
   import mxb_pkg::*;
#(
   parameter int LO_W   = 16,
   parameter int MID_W  = 4,
   parameter int TOP_W  = 4,
   parameter int ADDR_W = 24
) (
   input  mxb_phase_e         phase,
   input  logic [ADDR_W-1:0]  r_addr,
   input  logic [LO_W-1:0]    r_wdata,
   input  logic               r_write,
   input  logic               r_wide,
   input  logic               r_int,
   input  logic [TOP_W-1:0]   r_csel,
   input  logic [TOP_W-1:0]   cs_mode,
   output logic [LO_W-1:0]    ad_out,
   output logic [LO_W-1:0]    ad_oe,
   output logic [MID_W-1:0]   a_mid,
   output logic [TOP_W-1:0]   a_top,
   output logic               rd_n,
   output logic               wr_n
);
   localparam int BYTE_W = LO_W / 2;
   localparam int LANES  = 2;

   logic in_addr, in_data, in_stb, busy, ext;
   logic [BYTE_W-1:0] lane_out [LANES];
   logic              lane_oe  [LANES];
   logic [TOP_W-1:0]  cs_n;

   assign in_addr = (phase == PH_ADDR);
   assign in_data = phase_is_data(phase);
   assign in_stb  = phase_is_strobe(phase);
   assign busy    = (phase != PH_IDLE);
   assign ext     = !r_int;

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic              shared;
      logic [BYTE_W-1:0] l_addr, l_wd;
      assign l_addr = r_addr[ln*BYTE_W +: BYTE_W];
      assign l_wd   = r_wdata[ln*BYTE_W +: BYTE_W];
      if (ln == 0) begin : g_always_shared
         assign shared = 1'b1;
      end else begin : g_width_shared
         assign shared = r_wide;
      end
      assign lane_out[ln] = in_addr                       ? l_addr :
                            (in_data && !shared)          ? l_addr :
                            (in_data && r_write)          ? l_wd   : '0;
      assign lane_oe[ln]  = in_addr || (in_data && (!shared || r_write));
      assign ad_out[ln*BYTE_W +: BYTE_W] = lane_out[ln];
      assign ad_oe[ln*BYTE_W +: BYTE_W]  = {BYTE_W{lane_oe[ln]}};
   end

   assign a_mid = r_addr[LO_W +: MID_W];

   for (genvar i = 0; i < TOP_W; i++) begin : g_top
      assign cs_n[i]  = !(busy && ext && r_csel[i]);
      // reversed pairing: highest address line carries select 0
      assign a_top[i] = cs_mode[i] ? cs_n[TOP_W-1-i] : r_addr[LO_W+MID_W+i];
   end

   assign rd_n = !(in_stb && ext && !r_write);
   assign wr_n = !(in_stb && ext &&  r_write);
endmodule

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl
   import mxb_pkg::*;
#(
   parameter int LO_W     = 16,
   parameter int MID_W    = 4,
   parameter int TOP_W    = 4,
   parameter int ADDR_CYC = 2,
   parameter int STB_CYC  = 2,
   localparam int ADDR_W  = LO_W + MID_W + TOP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LO_W-1:0]   req_wdata,
   input  logic              req_write,
   input  logic              req_wide,
   input  logic              req_internal,
   input  logic [TOP_W-1:0]  req_csel,
   input  logic [TOP_W-1:0]  cs_mode,
   output logic              done,
   output logic [LO_W-1:0]   rdata,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic [LO_W-1:0]   ad_out,
   output logic [LO_W-1:0]   ad_oe,
   input  logic [LO_W-1:0]   ad_in,
   output logic [MID_W-1:0]  a_mid,
   output logic [TOP_W-1:0]  a_top,
   input  logic              ext_rdy
);
   if (ADDR_CYC < 2) begin : g_bad_addr
      $error("ADDR_CYC must be at least 2 so the address outlives the latch strobe");
   end
   if (STB_CYC < 1) begin : g_bad_stb
      $error("STB_CYC must be at least 1");
   end
   if ((LO_W % 2) != 0 || LO_W < 2) begin : g_bad_lo
      $error("LO_W must be an even width of two byte lanes");
   end

   mxb_phase_e        phase;
   logic              rdy_fall;
   logic [ADDR_W-1:0] r_addr;
   logic [LO_W-1:0]   r_wdata;
   logic              r_write, r_wide, r_int;
   logic [TOP_W-1:0]  r_csel;

   mxb_rdy_sample i_rdy (
      .clk      (clk),
      .rst_n    (rst_n),
      .rdy_pin  (ext_rdy),
      .rdy_fall (rdy_fall)
   );

   mxb_seq #(
      .LO_W(LO_W), .ADDR_W(ADDR_W), .CSN(TOP_W),
      .ADDR_CYC(ADDR_CYC), .STB_CYC(STB_CYC)
   ) i_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_write(req_write), .req_wide(req_wide), .req_internal(req_internal),
      .req_csel(req_csel), .rdy_fall(rdy_fall), .ad_in(ad_in),
      .req_ready(req_ready), .phase(phase), .ale(ale),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_write(r_write), .r_wide(r_wide),
      .r_int(r_int), .r_csel(r_csel), .done(done), .rdata(rdata)
   );

   mxb_pinmux #(
      .LO_W(LO_W), .MID_W(MID_W), .TOP_W(TOP_W), .ADDR_W(ADDR_W)
   ) i_pins (
      .phase(phase), .r_addr(r_addr), .r_wdata(r_wdata), .r_write(r_write),
      .r_wide(r_wide), .r_int(r_int), .r_csel(r_csel), .cs_mode(cs_mode),
      .ad_out(ad_out), .ad_oe(ad_oe), .a_mid(a_mid), .a_top(a_top),
      .rd_n(rd_n), .wr_n(wr_n)
   );

   AST_ALE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale) |-> $past(req_valid && req_ready))
      else $error("latch strobe without accepted request"); // R1

   AST_ALE_PINS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (ad_oe == {LO_W{1'b1}}))
      else $error("latch strobe with pins released"); // R2

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n))
      else $error("read and write strobes both low"); // R7

   AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT) |-> ($stable(ad_out) && $stable(ad_oe) && $stable(rd_n)
                              && $stable(wr_n) && $stable(ale) && $stable(a_mid)
                              && $stable(a_top)))
      else $error("pin moved during wait"); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle"); // R10

   AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (r_int && !req_ready) |-> (rd_n && wr_n))
      else $error("strobe on internal transfer"); // R11
endmodule

// File: tb/test_mxbus_ctrl.sv
module test_mxbus_ctrl;
   localparam int AC = 3;
   localparam int SC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0, req_internal = 1'b0;
   logic [23:0] req_addr = '0;
   logic [15:0] req_wdata = '0, ad_in = '0;
   logic [3:0]  req_csel = '0, cs_mode = '0;
   logic        ext_rdy = 1'b1;
   logic        req_ready, done, ale, rd_n, wr_n;
   logic [15:0] rdata, ad_out, ad_oe;
   logic [3:0]  a_mid, a_top;

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   mxbus_ctrl #(.ADDR_CYC(AC), .STB_CYC(SC)) i_mxbus_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
      .req_wide(req_wide), .req_internal(req_internal), .req_csel(req_csel),
      .cs_mode(cs_mode), .done(done), .rdata(rdata), .ale(ale), .rd_n(rd_n),
      .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
      .a_mid(a_mid), .a_top(a_top), .ext_rdy(ext_rdy)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] top_exp(logic [23:0] a, logic [3:0] cs, logic [3:0] m,
                                          logic act, logic intl);
      logic [3:0] r;
      for (int i = 0; i < 4; i++)
         r[i] = m[i] ? !(act && !intl && cs[3-i]) : a[20+i];
      return r;
   endfunction

   task automatic txn(logic [23:0] a, logic [15:0] wd, logic wr, logic wide,
                      logic intl, logic [3:0] cs, logic [3:0] m, int nw);
      logic [15:0] s_oe, s_out, din, rexp;
      logic [3:0]  t_act;
      int nwe;
      din   = ~a[15:0] ^ 16'h5a3c;
      s_oe  = wr ? 16'hffff : (wide ? 16'h0000 : 16'hff00);
      s_out = wr ? (wide ? wd : {a[15:8], wd[7:0]}) : (wide ? 16'h0 : {a[15:8], 8'h0});
      rexp  = intl ? 16'h0 : (wide ? din : {8'h0, din[7:0]});
      t_act = top_exp(a, cs, m, 1'b1, intl);
      nwe   = intl ? 0 : nw;
      @(posedge clk); #1;
      req_addr = a; req_wdata = wd; req_write = wr; req_wide = wide;
      req_internal = intl; req_csel = cs; cs_mode = m; ad_in = din; ext_rdy = 1'b1;
      req_valid = 1'b1;
      // address stage; request inputs scrambled meanwhile
      for (int c = 0; c < AC; c++) begin
         @(posedge clk); #1;
         req_addr = a ^ 24'hffffff; req_write = !wr; req_wdata = ~wd;
         req_wide = !wide; req_internal = !intl; req_csel = ~cs;
         #2;
         chk("R2 ale", ale, (c < AC-1));
         chk("R2 ad_out", ad_out, a[15:0]);
         chk("R2 ad_oe", ad_oe, 16'hffff);
         chk("R1 busy", req_ready, 0);
         chk("R5 a_mid", a_mid, a[19:16]);
         chk("R6 a_top", a_top, t_act);
         chk("R7 idle strobes", {rd_n, wr_n}, 2'b11);
      end
      for (int s = 0; s < SC; s++) begin
         @(posedge clk); #1;
         if (s == SC-1) begin req_valid = 1'b0; ext_rdy = (nw == 0); end
         #2;
         chk(wide ? "R4 oe" : "R3 oe", ad_oe, s_oe);
         chk(wide ? "R4 out" : "R3 out", ad_out & s_oe, s_out & s_oe);
         chk("R7 rd_n", rd_n, intl | wr);
         chk("R7 wr_n", wr_n, intl | !wr);
         chk("R6 a_top stb", a_top, t_act);
         chk("R5 a_mid stb", a_mid, a[19:16]);
         chk("R2 ale low", ale, 0);
      end
      for (int w = 1; w <= nwe; w++) begin
         @(posedge clk); #1;
         ext_rdy = (w == nwe);
         #2;
         chk("R8 in wait", done, 0);
         chk("R9 oe", ad_oe, s_oe);
         chk("R9 out", ad_out & s_oe, s_out & s_oe);
         chk("R9 strobes", {rd_n, wr_n}, {wr, !wr});
         chk("R9 top", {a_top, a_mid, ale}, {t_act, a[19:16], 1'b0});
      end
      @(posedge clk); #1;
      ext_rdy = 1'b1;
      #2;
      chk("R8 done after waits", done, 1);
      chk("R10 fin strobes", {rd_n, wr_n}, 2'b11);
      if (!wr) chk(intl ? "R11 rdata" : "R10 rdata", rdata, rexp);
      @(posedge clk); #3;
      chk("R10 pulse", done, 0);
      chk("R1 idle", req_ready, 1);
      chk("R1 idle pins", {ale, rd_n, wr_n, ad_oe}, {3'b011, 16'h0});
      chk("R6 idle cs", a_top & m, m);
      if (!wr) chk("R10 rdata held", rdata, rexp);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #3;
      chk("R1 reset ready", req_ready, 1);
      chk("R1 reset pins", {done, ale, rd_n, wr_n, ad_oe}, {4'b0011, 16'h0});
      rst_n = 1'b1;
      begin
         int k = 0;
         for (int wide = 0; wide < 2; wide++)
            for (int wr = 0; wr < 2; wr++)
               for (int intl = 0; intl < 2; intl++)
                  for (int nw = 0; nw < 4; nw++) begin
                     logic [23:0] a;
                     a = 24'(32'h00a53c71 * (k + 3)) ^ 24'(k << 20);
                     txn(a, 16'(32'h9e37 * (k + 1)), wr[0], wide[0], intl[0],
                         4'(1 << (k % 4)), 4'(k), nw);
                     k++;
                  end
         for (int m = 0; m < 16; m++)
            txn(24'(32'h0f1e2d * (m + 1)), 16'(m * 4661), 1'b0, 1'b1, 1'b0,
                4'(1 << (m % 4)), 4'(m), 1);
      end
      // request while idle with nothing asserted: remain idle
      repeat (3) @(posedge clk);
      #3;
      chk("R1 stays idle", {req_ready, ale}, 2'b10);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      finished = 1;
      $finish;
   end

   initial begin
      #400000;
      if (!finished) begin
         n_bad++;
         n_cmp++;
         $display("FAIL R1 watchdog actual=%h expected=%h", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule